// File: doc/BRIEF.md
# Transmit Byte Queue with Latched Error Status

This block is a byte-wide first-in first-out queue placed between a host that loads transmit data and a serializer that drains it one byte at a time. The host pushes bytes with a write strobe. The serializer pulls bytes with a read strobe and holds a packet-active line high while a frame is going out. A flush command empties the queue in a single cycle.

An eight-bit status word reports the state of the queue:
- A full indication with hysteresis. It asserts at capacity and releases only once the fill level falls below a programmable threshold.
- A level comparison against that same threshold.
- Two latched error bits: one for writes refused by a full queue, one for reads made on an empty queue during a packet.
- A latched marker showing that the sync word has finished.

The error bits and the sync marker stay set until the next flush, so firmware can read them at any later time.

Top module: `txq_status_fifo`

## Requirements
- R1: When the fill level reaches DEPTH, status bit 3 (full) goes high. A write made at a fill level of DEPTH is dropped, and it leaves the stored bytes and their order unchanged.
- R2: After status bit 3 has gone high, it stays high while reads lower the fill level, until the level falls below `thresh_i`. It is then cleared in the same cycle that the level update takes effect.
- R3: Status bit 2 is high exactly when the fill level is greater than or equal to `thresh_i`, where `thresh_i` is in the range 1 to DEPTH.
- R4: A write request at a fill level of DEPTH sets status bit 1 (overflow) on the next clock edge. The bit then stays set until a flush.
- R5: A read request at a fill level of 0 while `pkt_active_i` is high sets status bit 0 (underflow) on the next clock edge. The bit stays set until a flush. A read at a fill level of 0 with `pkt_active_i` low sets nothing. No read at an empty queue moves the read position.
- R6: Bytes leave in the order they were written, and `rd_data_o` presents the byte on the clock edge that accepts the read. A read and a write in the same cycle, at a level strictly between 0 and DEPTH, leave the fill level unchanged.
- R7: Asserting `flush_i` empties the queue and clears status bits 4:0 on the next edge. A write, read or sync pulse in the same cycle is ignored.
- R8: A one-cycle pulse on `sync_done_i` sets status bit 4 (sync sent). The bit stays set until a flush.
- R9: Status bits 7:6 always read 0, and every status bit is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and clear latched status |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Serializer read strobe |
| rd_data_o | output | 8 | Byte taken by the last accepted read |
| pkt_active_i | input | 1 | A packet is being sent |
| sync_done_i | input | 1 | Pulse: last sync-word bit has gone out |
| thresh_i | input | $clog2(DEPTH+1) | Fill threshold, 1 to DEPTH |
| status_o | output | 8 | {2'b00, sync, full, at/over threshold, overflow, underflow} |

## Verification
A flush can fall in the same cycle as a write, a read or a sync pulse. The sharpest case is a flush that coincides with a write to a queue already holding DEPTH bytes, which would otherwise latch overflow. The bench fills the queue, then raises the flush and the write strobe in the same cycle. It judges the result at the ports: the status word must be zero and the next byte read must be the first byte written after the flush. A second collision, a read and a write in the same cycle at a partial fill level, is judged by comparing the threshold flag at two threshold values.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef struct packed {
        logic sync;
        logic full;
        logic ovf;
        logic udf;
    } txq_flags_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_req_i,
    input  logic             rd_req_i,
    input  logic             pkt_active_i,
    input  logic             sync_done_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             wr_fire_o,
    output logic             rd_fire_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] count_o,
    output txq_flags_t       flags_o
);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        txq_flags_t       flags;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     wr_fire_d, rd_fire_d;
    logic     at_cap, at_empty;

    always_comb begin
        st_d      = st_q;
        at_cap    = (st_q.count == CAP);
        at_empty  = (st_q.count == '0);
        wr_fire_d = wr_req_i && !flush_i && !at_cap;
        rd_fire_d = rd_req_i && !flush_i && !at_empty;

        if (wr_fire_d)
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        if (rd_fire_d)
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;

        unique case ({wr_fire_d, rd_fire_d})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase

        if (wr_req_i && at_cap)                 st_d.flags.ovf  = 1'b1;
        if (rd_req_i && at_empty && pkt_active_i) st_d.flags.udf = 1'b1;
        if (sync_done_i)                        st_d.flags.sync = 1'b1;

        if (st_d.count == CAP)          st_d.flags.full = 1'b1;
        else if (st_d.count < thresh_i) st_d.flags.full = 1'b0;

        if (flush_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_fire_o = wr_fire_d;
    assign rd_fire_o = rd_fire_d;
    assign wr_ptr_o  = st_q.wr_ptr;
    assign rd_ptr_o  = st_q.rd_ptr;
    assign count_o   = st_q.count;
    assign flags_o   = st_q.flags;
endmodule

// File: rtl/txq_status_fifo.sv
module txq_status_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_en_i,
    output logic [7:0]       rd_data_o,
    input  logic             pkt_active_i,
    input  logic             sync_done_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic [7:0]       status_o
);
    logic             wr_fire, rd_fire;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill_w;
    txq_flags_t       flags;

    txq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .wr_req_i     (wr_en_i),
        .rd_req_i     (rd_en_i),
        .pkt_active_i (pkt_active_i),
        .sync_done_i  (sync_done_i),
        .thresh_i     (thresh_i),
        .wr_fire_o    (wr_fire),
        .rd_fire_o    (rd_fire),
        .wr_ptr_o     (wr_ptr),
        .rd_ptr_o     (rd_ptr),
        .count_o      (fill_w),
        .flags_o      (flags)
    );

    txq_store #(.DEPTH(DEPTH), .DATA_W(8)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire),
        .waddr (wr_ptr),
        .wdata (wr_data_i),
        .re    (rd_fire),
        .raddr (rd_ptr),
        .rdata (rd_data_o)
    );

    assign status_o = {2'b00, flags.sync, flags.full, (fill_w >= thresh_i),
                       flags.ovf, flags.udf};
endmodule

// File: rtl/txq_status_fifo_chk.sv
module txq_status_fifo_chk #(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             wr_en_i,
    input logic             rd_en_i,
    input logic             pkt_active_i,
    input logic             sync_done_i,
    input logic [CNT_W-1:0] thresh_i,
    input logic [7:0]       status_o,
    input logic [CNT_W-1:0] fill
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    assert_full_at_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill == CAP |-> status_o[3]);

    assert_no_overrun_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CAP);

    assert_full_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[3]) |-> fill < thresh_i);

    assert_thr_at_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill == CAP |-> status_o[2]);

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && fill == CAP && !flush_i) |=> status_o[1]);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1] && !flush_i) |=> status_o[1]);

    assert_udf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && pkt_active_i && fill == '0 && !flush_i) |=> status_o[0]);

    assert_udf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !flush_i) |=> status_o[0]);

    assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (status_o[4:0] == 5'd0 && fill == '0));

    assert_sync_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_done_i && !flush_i) |=> status_o[4]);

    assert_top_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == 2'b00);
endmodule

bind txq_status_fifo txq_status_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .pkt_active_i (pkt_active_i),
    .sync_done_i  (sync_done_i),
    .thresh_i     (thresh_i),
    .status_o     (status_o),
    .fill         (fill_w)
);

// File: tb/txq_status_fifo_tb_top.sv
module txq_status_fifo_tb_top;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [7:0]       wr_data_i = '0;
    logic             rd_en_i = 1'b0;
    logic [7:0]       rd_data_o;
    logic             pkt_active_i = 1'b0;
    logic             sync_done_i = 1'b0;
    logic [CNT_W-1:0] thresh_i = CNT_W'(DEPTH);
    logic [7:0]       status_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txq_status_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .rd_en_i      (rd_en_i),
        .rd_data_o    (rd_data_o),
        .pkt_active_i (pkt_active_i),
        .sync_done_i  (sync_done_i),
        .thresh_i     (thresh_i),
        .status_o     (status_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_stat(input string req, input logic [7:0] exp);
        check(status_o == exp, req, status_o, exp);
    endtask

    // One clock: drive at negedge, let the edge pass, return at next negedge.
    task automatic cyc(input bit wr, input logic [7:0] wd, input bit rd,
                       input bit fl, input bit sd);
        wr_en_i = wr; wr_data_i = wd; rd_en_i = rd; flush_i = fl; sync_done_i = sd;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0; flush_i = 1'b0; sync_done_i = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        cyc(1'b1, b, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pop_expect(input string req, input logic [7:0] exp);
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check(rd_data_o == exp, req, rd_data_o, exp);
    endtask

    task automatic do_flush();
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        chk_stat("R9 reset", 8'h00);
    endtask

    task automatic t_order();
        do_flush();
        thresh_i = CNT_W'(DEPTH);
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
        for (int i = 0; i < 5; i++) pop_expect("R6 order", 8'hA0 + 8'(i));
        for (int i = 0; i < 3; i++) push(8'h50 + 8'(i));
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 8'h60 + 8'(i), 1'b1, 1'b0, 1'b0);
            check(rd_data_o == (i < 3 ? 8'h50 + 8'(i) : 8'h60),
                  "R6 concurrent", rd_data_o, (i < 3 ? 8'h50 + i : 8'h60));
        end
        thresh_i = 3; #1;
        check(status_o[2] == 1'b1, "R6 level kept (>=3)", status_o[2], 1);
        thresh_i = 4; #1;
        check(status_o[2] == 1'b0, "R6 level kept (<4)", status_o[2], 0);
    endtask

    task automatic t_fill();
        do_flush();
        thresh_i = 10;
        for (int i = 0; i < 9; i++) push(8'h10 + 8'(i));
        check(status_o[2] == 1'b0, "R3 below threshold", status_o[2], 0);
        push(8'h19);
        check(status_o[2] == 1'b1, "R3 at threshold", status_o[2], 1);
        for (int i = 10; i < DEPTH; i++) push(8'h10 + 8'(i));
        check(status_o[3] == 1'b1, "R1 full at capacity", status_o[3], 1);
        check(status_o[1] == 1'b0, "R4 no overflow yet", status_o[1], 0);
        push(8'hEE);
        check(status_o[1] == 1'b1, "R4 overflow set", status_o[1], 1);
        for (int i = 0; i < 6; i++) pop_expect("R1 contents", 8'h10 + 8'(i));
        check(status_o[3] == 1'b1, "R2 full held at threshold", status_o[3], 1);
        pop_expect("R1 contents", 8'h16);
        check(status_o[3] == 1'b0, "R2 full released below threshold", status_o[3], 0);
        for (int i = 7; i < DEPTH; i++) pop_expect("R1 contents", 8'h10 + 8'(i));
        check(status_o[1] == 1'b1, "R4 overflow sticky", status_o[1], 1);
        do_flush();
        chk_stat("R7 flush clears", 8'h00);
    endtask

    task automatic t_underflow();
        do_flush();
        thresh_i = 1;
        pkt_active_i = 1'b0;
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check(status_o[0] == 1'b0, "R5 idle empty read ignored", status_o[0], 0);
        pkt_active_i = 1'b1;
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check(status_o[0] == 1'b1, "R5 underflow set", status_o[0], 1);
        pkt_active_i = 1'b0;
        push(8'hB0);
        push(8'hB1);
        pop_expect("R5 pointer unmoved", 8'hB0);
        check(status_o[0] == 1'b1, "R5 underflow sticky", status_o[0], 1);
        do_flush();
        chk_stat("R7 flush clears underflow", 8'h00);
    endtask

    task automatic t_flush_collide();
        do_flush();
        thresh_i = 1;
        for (int i = 0; i < DEPTH; i++) push(8'hC0 + 8'(i));
        check(status_o[3] == 1'b1, "R1 full", status_o[3], 1);
        cyc(1'b1, 8'hEE, 1'b0, 1'b1, 1'b1);
        chk_stat("R7 flush beats write/sync", 8'h00);
        push(8'hD5);
        pop_expect("R7 empty after flush", 8'hD5);
        check(status_o[2] == 1'b0, "R7 level zero", status_o[2], 0);
    endtask

    task automatic t_sync();
        do_flush();
        thresh_i = CNT_W'(DEPTH);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk_stat("R8 sync set", 8'h10);
        push(8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check(status_o[4] == 1'b1, "R8 sync sticky", status_o[4], 1);
        check(status_o[7:6] == 2'b00, "R9 top bits zero", status_o[7:6], 0);
        do_flush();
        chk_stat("R8 cleared by flush", 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_fill();
        t_underflow();
        t_flush_collide();
        t_sync();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule